// File: doc/BRIEF.md
# Zero-Delay Clock Divider and Alignment Control

This block is the digital control that sits around a zero-delay clock multiplier. It runs on one fast system clock. Two single-cycle strobes mark rising edges: `ref_edge` for the incoming reference clock and `main_edge` for the primary output clock. A reference counter divides the reference edge stream by a programmable ratio. A feedback counter divides the feedback edge stream by a second ratio. The feedback edge stream comes either from the primary output or from the rising edges of the secondary output when that output runs at half rate. Each ratio is a 7-bit word plus two.

When both counters wrap on the same system cycle, the rising edges are aligned. The block then raises a one-cycle `align_o` pulse. The secondary output has three modes: high impedance, the alignment pulse, or the primary output divided by two. A power-down input turns the block off and floats both outputs. A change to either divide word restarts the counting from zero, so the first alignment pulse after a change marks the first common wrap. A configuration error flag is raised when the secondary output is chosen as feedback while it is not running at half rate.

Top module: `zdb_sync_ctrl`

## Requirements
- R1: The reference counter counts `ref_edge` strobes and wraps on every (ref_word+2)-th strobe after a restart.
- R2: A feedback edge is every `main_edge` when `fb_from_out2`=0. When `fb_from_out2`=1, a feedback edge is a `main_edge` that takes the half-rate output from 0 to 1, which is the 1st, 3rd, 5th and so on after a restart. The feedback counter wraps on every (fb_word+2)-th feedback edge.
- R3: `align_o` is high for exactly the one cycle after a cycle in which the reference counter and the feedback counter both wrap. Otherwise it is low.
- R4: With `out2_oe`=0, `out2_en` is 0 and `out2_val` is 0, whatever the value of `out2_half`.
- R5: With `out2_oe`=1 and `out2_half`=0, `out2_val` equals `align_o` AND `sync_ok`. With `sync_ok`=0 it stays 0.
- R6: With `out2_oe`=1 and `out2_half`=1, `out2_val` starts at 0 after a restart. It toggles one cycle after each `main_edge`.
- R7: While `sleep_n`=0, `out1_en`, `out2_en`, `out2_val` and `align_o` are all 0 and all counting state is held at zero. After release, the first `align_o` marks the first common wrap.
- R8: On a cycle in which `ref_word` or `fb_word` differs from its value on the previous cycle, both counters and the half-rate flip-flop clear, that cycle's strobes are ignored, and `align_o` is 0 on the next cycle.
- R9: `cfg_err` = `fb_from_out2` AND NOT (`out2_oe` AND `out2_half`), and it is combinational.
- R10: Both words at their all-ones idle value (127) give a ratio of 129. With both strobes on every cycle, the first `align_o` follows the 129th strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_n | input | 1 | Power-down, active low; floats both outputs |
| ref_edge | input | 1 | One-cycle strobe per reference clock rising edge |
| main_edge | input | 1 | One-cycle strobe per primary output rising edge |
| ref_word | input | 7 | Reference divide word; the ratio is word+2 |
| fb_word | input | 7 | Feedback divide word; the ratio is word+2 |
| out2_oe | input | 1 | Secondary output enable |
| out2_half | input | 1 | Secondary output: 1 = half rate, 0 = alignment pulse |
| sync_ok | input | 1 | Configuration flag that allows the alignment pulse on the secondary output |
| fb_from_out2 | input | 1 | Feedback taken from the secondary output when 1 |
| out1_en | output | 1 | Primary output driven (0 = high impedance) |
| out2_en | output | 1 | Secondary output driven (0 = high impedance) |
| out2_val | output | 1 | Secondary output value |
| align_o | output | 1 | Aligned-edge pulse |
| cfg_err | output | 1 | Illegal feedback selection |

## Verification
The assertions take for granted that the edge strobes are single-cycle events sampled on the system clock. They also assume the divide words are held steady between deliberate changes, since any change is treated as a restart. The bench drives strobes on fixed periodic grids and changes words only on a quiet cycle at the start of each configuration. It takes a power-down pulse before it switches the feedback source, so the half-rate phase is always known. Expected pulses come from edge indices since the restart, tested for divisibility by the two ratios.

// File: rtl/zdb_pkg.sv
package zdb_pkg;
  localparam int unsigned DIV_OFFSET = 2;

  typedef enum logic [1:0] {
    O2_FLOAT = 2'd0,
    O2_ALIGN = 2'd1,
    O2_HALF  = 2'd2
  } out2_mode_t;

  function automatic out2_mode_t pick_out2_mode(input logic oe, input logic half);
    if (!oe)      return O2_FLOAT;
    else if (half) return O2_HALF;
    else          return O2_ALIGN;
  endfunction

  function automatic logic fb_select_bad(input logic fb_out2, input out2_mode_t mode);
    return fb_out2 && (mode != O2_HALF);
  endfunction
endpackage

// File: rtl/zdb_edge_div.sv
module zdb_edge_div #(
  parameter int WORD_W = 7,
  parameter int OFFSET = 2,
  localparam int CNT_W = $clog2((1 << WORD_W) + OFFSET)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap
);
  logic [CNT_W-1:0] last_val;
  logic             at_last;

  assign last_val = CNT_W'(word) + CNT_W'(OFFSET - 1);
  assign at_last  = (cnt == last_val);
  assign wrap     = step && at_last && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/zdb_half_div.sv
module zdb_half_div (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic half_q,
  output logic rise
);
  assign rise = tick && !half_q && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     half_q <= 1'b0;
    else if (clr)   half_q <= 1'b0;
    else if (tick)  half_q <= !half_q;
  end
endmodule

// File: rtl/zdb_out2_mux.sv
module zdb_out2_mux
  import zdb_pkg::*;
(
  input  out2_mode_t mode,
  input  logic       awake,
  input  logic       half_q,
  input  logic       pulse,
  input  logic       sync_ok,
  output logic       out2_en,
  output logic       out2_val
);
  always_comb begin
    out2_en  = 1'b0;
    out2_val = 1'b0;
    if (awake) begin
      unique case (mode)
        O2_HALF: begin
          out2_en  = 1'b1;
          out2_val = half_q;
        end
        O2_ALIGN: begin
          out2_en  = 1'b1;
          out2_val = pulse && sync_ok;
        end
        default: begin
          out2_en  = 1'b0;
          out2_val = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/zdb_sync_ctrl.sv
module zdb_sync_ctrl
  import zdb_pkg::*;
#(
  parameter int WORD_W = 7,
  localparam int CNT_W = $clog2((1 << WORD_W) + DIV_OFFSET)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_n,
  input  logic              ref_edge,
  input  logic              main_edge,
  input  logic [WORD_W-1:0] ref_word,
  input  logic [WORD_W-1:0] fb_word,
  input  logic              out2_oe,
  input  logic              out2_half,
  input  logic              sync_ok,
  input  logic              fb_from_out2,
  output logic              out1_en,
  output logic              out2_en,
  output logic              out2_val,
  output logic              align_o,
  output logic              cfg_err
);
  logic [WORD_W-1:0] ref_prev, fb_prev;
  logic              words_moved, restart, awake;
  logic              half_q, half_rise, fb_edge;
  logic              ref_wrap, fb_wrap, coincide;
  logic [CNT_W-1:0]  ref_cnt, fb_cnt;
  out2_mode_t        mode;

  assign awake       = sleep_n;
  assign words_moved = (ref_word != ref_prev) || (fb_word != fb_prev);
  assign restart     = !awake || words_moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev <= '1;
      fb_prev  <= '1;
    end else begin
      ref_prev <= ref_word;
      fb_prev  <= fb_word;
    end
  end

  zdb_half_div u_half (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (restart),
    .tick   (main_edge),
    .half_q (half_q),
    .rise   (half_rise)
  );

  assign fb_edge = fb_from_out2 ? half_rise : main_edge;

  zdb_edge_div #(.WORD_W(WORD_W), .OFFSET(DIV_OFFSET)) u_ref_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .step  (ref_edge),
    .word  (ref_word),
    .cnt   (ref_cnt),
    .wrap  (ref_wrap)
  );

  zdb_edge_div #(.WORD_W(WORD_W), .OFFSET(DIV_OFFSET)) u_fb_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .step  (fb_edge),
    .word  (fb_word),
    .cnt   (fb_cnt),
    .wrap  (fb_wrap)
  );

  assign coincide = ref_wrap && fb_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       align_o <= 1'b0;
    else if (restart) align_o <= 1'b0;
    else              align_o <= coincide;
  end

  assign mode = pick_out2_mode(out2_oe, out2_half);

  zdb_out2_mux u_mux (
    .mode     (mode),
    .awake    (awake),
    .half_q   (half_q),
    .pulse    (align_o),
    .sync_ok  (sync_ok),
    .out2_en  (out2_en),
    .out2_val (out2_val)
  );

  assign out1_en = awake;
  assign cfg_err = fb_select_bad(fb_from_out2, mode);
endmodule

// File: rtl/zdb_sync_chk.sv
module zdb_sync_chk #(
  parameter int WORD_W = 7,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_n,
  input logic              out2_oe,
  input logic              out2_half,
  input logic              out1_en,
  input logic              out2_en,
  input logic              out2_val,
  input logic              align_o,
  input logic              ref_wrap,
  input logic              fb_wrap,
  input logic              restart,
  input logic              half_q,
  input logic              main_edge,
  input logic [CNT_W-1:0]  ref_cnt,
  input logic [WORD_W-1:0] ref_word
);
  logic [CNT_W-1:0] ref_top;
  assign ref_top = CNT_W'(ref_word) + CNT_W'(1);

  a_r1_ref_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> ref_cnt <= ref_top);

  a_r3_align_cause: assert property (@(posedge clk) disable iff (!rst_n)
    align_o |-> $past(ref_wrap && fb_wrap));

  a_r4_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !out2_oe |-> !out2_en && !out2_val);

  a_r5_pulse_only_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (out2_en && !out2_half && out2_val) |-> align_o);

  a_r6_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(main_edge) && !$past(restart)) |-> $stable(half_q));

  a_r7_sleep_float: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !out1_en && !out2_en && !out2_val);

  a_r8_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (ref_cnt == '0) && !half_q && !align_o);
endmodule

bind zdb_sync_ctrl zdb_sync_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_n   (sleep_n),
  .out2_oe   (out2_oe),
  .out2_half (out2_half),
  .out1_en   (out1_en),
  .out2_en   (out2_en),
  .out2_val  (out2_val),
  .align_o   (align_o),
  .ref_wrap  (ref_wrap),
  .fb_wrap   (fb_wrap),
  .restart   (restart),
  .half_q    (half_q),
  .main_edge (main_edge),
  .ref_cnt   (ref_cnt),
  .ref_word  (ref_word)
);

// File: tb/test_zdb_sync_ctrl.sv
module test_zdb_sync_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_n = 1'b1;
  logic       ref_edge = 1'b0;
  logic       main_edge = 1'b0;
  logic [6:0] ref_word = 7'h7f;
  logic [6:0] fb_word = 7'h7f;
  logic       out2_oe = 1'b1;
  logic       out2_half = 1'b0;
  logic       sync_ok = 1'b1;
  logic       fb_from_out2 = 1'b0;
  logic       out1_en, out2_en, out2_val, align_o, cfg_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zdb_sync_ctrl i_zdb_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n),
    .ref_edge(ref_edge), .main_edge(main_edge),
    .ref_word(ref_word), .fb_word(fb_word),
    .out2_oe(out2_oe), .out2_half(out2_half), .sync_ok(sync_ok),
    .fb_from_out2(fb_from_out2),
    .out1_en(out1_en), .out2_en(out2_en), .out2_val(out2_val),
    .align_o(align_o), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One configuration: quiet restart cycle, then periodic strobes.
  task automatic run_cfg(input int rw, input int fw, input bit fsel,
                         input int pref, input int pmain, input int len, input bit need_align);
    int rr = rw + 2;
    int rf = fw + 2;
    int n_ref = 0, n_main = 0, n_fb = 0, want = 0, seen = 0;
    bit e_al, fbev, r, m, par;
    @(negedge clk);
    ref_word = 7'(rw); fb_word = 7'(fw); fb_from_out2 = fsel;
    ref_edge = 1'b0; main_edge = 1'b0;
    @(negedge clk);
    chk("R8", "align after word change", int'(align_o), 0);
    chk("R8", "out2 after word change", int'(out2_val), 0);
    par = 1'b0;
    for (int t = 1; t <= len; t++) begin
      r = (t % pref) == 0;
      m = (t % pmain) == 0;
      fbev = 1'b0;
      if (r) n_ref++;
      if (m) begin
        n_main++;
        par = n_main[0];
        if (!fsel || n_main[0]) begin
          fbev = 1'b1;
          n_fb++;
        end
      end
      e_al = r && fbev && (n_ref % rr == 0) && (n_fb % rf == 0);
      want += int'(e_al);
      ref_edge = r; main_edge = m;
      @(negedge clk);
      chk("R3", "align pulse", int'(align_o), int'(e_al));
      if (!out2_oe)       chk("R4", "out2 floated value", int'(out2_val), 0);
      else if (out2_half) chk("R6", "half-rate out2", int'(out2_val), int'(par));
      else                chk("R5", "pulse on out2", int'(out2_val), int'(e_al && sync_ok));
      chk("R4", "out2 enable", int'(out2_en), int'(out2_oe));
      seen += int'(align_o);
    end
    ref_edge = 1'b0; main_edge = 1'b0;
    chk(fsel ? "R2" : "R1", "pulse count", seen, want);
    if (need_align) chk("R2", "some alignment", int'(want > 0), 1);
  endtask

  task automatic sleep_pulse();
    @(negedge clk);
    sleep_n = 1'b0; ref_edge = 1'b1; main_edge = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7", "out1 floated", int'(out1_en), 0);
      chk("R7", "out2 floated", int'(out2_en), 0);
      chk("R7", "no pulse asleep", int'(align_o), 0);
    end
    sleep_n = 1'b1; ref_edge = 1'b0; main_edge = 1'b0;
    @(negedge clk);
    chk("R7", "out1 back", int'(out1_en), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "reset align", int'(align_o), 0);
    chk("R5", "reset out2", int'(out2_val), 0);
    chk("R7", "reset out1 enable", int'(out1_en), 1);
    chk("R9", "reset cfg_err", int'(cfg_err), 0);

    // R10: idle all-ones words give ratio 129
    run_cfg(127, 127, 1'b0, 1, 1, 131, 1'b1);

    // R1 R2 sweep with the primary output as feedback, pulse mode
    sleep_pulse();
    out2_oe = 1'b1; out2_half = 1'b0; sync_ok = 1'b1;
    for (int rw = 0; rw < 4; rw++)
      for (int fw = 0; fw < 4; fw++)
        run_cfg(rw, fw, 1'b0, fw + 2, rw + 2, 4 * (rw + 2) * (fw + 2) + 3, 1'b1);

    // R2 R6 sweep with the half-rate output as feedback
    sleep_pulse();
    out2_half = 1'b1;
    for (int rw = 0; rw < 4; rw++)
      for (int fw = 0; fw < 4; fw++)
        run_cfg(rw, fw, 1'b1, 1, rw + 2, 4 * (rw + 2) * (fw + 2) + 3, 1'b1);

    // R5: pulse mode with sync not allowed
    sleep_pulse();
    out2_half = 1'b0; sync_ok = 1'b0;
    run_cfg(1, 2, 1'b0, 4, 3, 40, 1'b1);
    sync_ok = 1'b1;

    // R4: secondary output disabled in both half settings
    out2_oe = 1'b0; out2_half = 1'b1;
    run_cfg(2, 1, 1'b0, 3, 4, 30, 1'b1);
    out2_half = 1'b0;
    run_cfg(1, 1, 1'b0, 3, 3, 20, 1'b1);
    out2_oe = 1'b1;

    // R9: error flag over every selection
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      fb_from_out2 = v[0]; out2_oe = v[1]; out2_half = v[2];
      #1;
      chk("R9", "cfg_err", int'(cfg_err), int'(v[0] && !(v[1] && v[2])));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule